// File: doc/BRIEF.md
# E3 Synchronization Status Message Receiver

This block recovers the four-bit synchronization status message that a G.832 E3 transmitter sends one bit per frame inside the maintenance-and-adaptation (MA) byte. Each frame delivers a single message bit together with a two-bit position tag in the same byte. The block puts the bits back in place according to their tags. It checks that the tags advance by one from frame to frame. It commits a message only after all four positions have arrived in order.

The committed message is held on `ssm_word`. Two sticky flags report events to the host. `flag_change` records that a newly committed message differs from the stored one. `flag_order` records a tag that broke the expected sequence. `irq` is the OR of the two flags. Each flag is cleared by its own one-cycle read strobe. A receive-enable input freezes all of this state while it is low. When the enable returns, reassembly and the sequence check both start again from the beginning.

The reassembly controller has four states. `ASM_HUNT` waits for a tag of 00. `ASM_HAVE1`, `ASM_HAVE2` and `ASM_HAVE3` mean that one, two or three consecutive positions have been collected. The transitions are as follows. HUNT goes to HAVE1 when tag 00 arrives. Each HAVEn goes to the next state when the expected tag arrives. HAVE3 goes back to HUNT, committing the message, when tag 11 arrives. Any unexpected tag sends the controller to HAVE1 if that tag is 00, and to HUNT otherwise.

Top module: `e3_ssm_rx`

## Requirements
- R1: On a frame strobe, the message bit is `ma_byte[0]` (G.832 bit 8). The tag is {`ma_byte[2]`, `ma_byte[1]`} (bits 6 and 7). Tag 00 places the bit on `ssm_word[3]`, 01 on `ssm_word[2]`, 10 on `ssm_word[1]`, and 11 on `ssm_word[0]`.
- R2: `ssm_word` updates only in the cycle after the strobe of a tag-11 frame, and only when the three frames before it carried tags 00, 01 and 10 in consecutive order.
- R3: The first message committed after reset, or after the enable returns high, is stored without setting `flag_change`.
- R4: A committed message that differs from the stored one sets `flag_change` in the cycle after the commit. An identical message leaves the flag unchanged.
- R5: A frame whose tag is not the previous frame's tag plus one (modulo 4) sets `flag_order` one cycle after its strobe. The first frame after reset or after re-enable is never flagged.
- R6: An out-of-sequence frame discards the partial message. Reassembly restarts at a frame with tag 00, and this includes the offending frame itself when its tag is 00.
- R7: While `rx_en` is low, frame strobes and read strobes are ignored, and `ssm_word`, `flag_change` and `flag_order` hold their values.
- R8: A read strobe clears its flag in the next cycle. If the flag is set in the same cycle as its read strobe, the flag stays set.
- R9: `irq` is high exactly when `flag_change` or `flag_order` is high.
- R10: After reset, `ssm_word` is 0 and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe per received frame |
| ma_byte | input | 8 | MA byte, valid with `frame_stb` |
| rx_en | input | 1 | Receive enable |
| rd_change | input | 1 | Read strobe that clears `flag_change` |
| rd_order | input | 1 | Read strobe that clears `flag_order` |
| ssm_word | output | 4 | Last committed message (bit 3 = first message bit) |
| flag_change | output | 1 | Sticky flag: message changed |
| flag_order | output | 1 | Sticky flag: tag out of sequence |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are those where sequence breaks overlap with reassembly. One is a tag of 00 that arrives mid-message: it must both raise `flag_order` and start a fresh message whose earlier bits are then overwritten. Another is a read strobe that lands in the same cycle as a new out-of-sequence frame. The stimulus builds these deliberately. It sends partial messages with bit values that would produce a visibly different word if stale bits survived, and it drives read strobes together with frame strobes. A disabled window with frames and reads applied, followed by a first frame whose tag would otherwise be out of order, covers the restart after re-enable.

// File: rtl/e3_ssm_pkg.sv
package e3_ssm_pkg;
    localparam int SSM_W = 4;
    localparam int TAG_W = 2;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [SSM_W-1:0] ssm_t;

    typedef enum logic [1:0] {
        ASM_HUNT  = 2'd0,
        ASM_HAVE1 = 2'd1,
        ASM_HAVE2 = 2'd2,
        ASM_HAVE3 = 2'd3
    } asm_state_e;
endpackage

// File: rtl/e3_ssm_seq_chk.sv
module e3_ssm_seq_chk
    import e3_ssm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic stb,
    input  tag_t tag,
    output logic order_evt
);
    tag_t prev_tag;
    logic have_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_tag  <= '0;
            have_prev <= 1'b0;
        end else if (!en) begin
            have_prev <= 1'b0;
        end else if (stb) begin
            prev_tag  <= tag;
            have_prev <= 1'b1;
        end
    end

    always_comb begin
        order_evt = en && stb && have_prev && (tag != tag_t'(prev_tag + 1'b1));
    end

    // First frame after a restart is never flagged
    assert_restart_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> !(order_evt && $past(!en)));
endmodule

// File: rtl/e3_ssm_asm.sv
module e3_ssm_asm
    import e3_ssm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic stb,
    input  tag_t tag,
    input  logic data_bit,
    output logic commit,
    output ssm_t word
);
    asm_state_e state, state_nx;
    ssm_t       partial;
    tag_t       expect_tag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ASM_HUNT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx   = state;
        commit     = 1'b0;
        expect_tag = tag_t'(state);
        if (!en) begin
            state_nx = ASM_HUNT;
        end else if (stb) begin
            unique case (state)
                ASM_HUNT: begin
                    if (tag == 2'b00) state_nx = ASM_HAVE1;
                end
                ASM_HAVE1, ASM_HAVE2: begin
                    if (tag == expect_tag)
                        state_nx = (state == ASM_HAVE1) ? ASM_HAVE2 : ASM_HAVE3;
                    else
                        state_nx = (tag == 2'b00) ? ASM_HAVE1 : ASM_HUNT;
                end
                ASM_HAVE3: begin
                    if (tag == 2'b11) begin
                        state_nx = ASM_HUNT;
                        commit   = 1'b1;
                    end else begin
                        state_nx = (tag == 2'b00) ? ASM_HAVE1 : ASM_HUNT;
                    end
                end
                default: state_nx = ASM_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            partial <= '0;
        end else if (en && stb) begin
            partial[SSM_W-1-int'(tag)] <= data_bit;
        end
    end

    always_comb begin
        word    = partial;
        word[0] = data_bit;
    end

    assert_commit_on_last_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (stb && en && tag == 2'b11));
endmodule

// File: rtl/e3_ssm_sticky.sv
module e3_ssm_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set,
    input  logic rd,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (en) begin
            if (set)      flag <= 1'b1;
            else if (rd)  flag <= 1'b0;
        end
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && set) |=> flag);
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rd && !set) |=> !flag);
endmodule

// File: rtl/e3_ssm_rx.sv
module e3_ssm_rx
    import e3_ssm_pkg::*;
#(
    parameter int MA_W        = 8,
    parameter int DATA_POS    = 0,
    parameter int TAG_MSB_POS = 2,
    parameter int TAG_LSB_POS = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_stb,
    input  logic [MA_W-1:0] ma_byte,
    input  logic            rx_en,
    input  logic            rd_change,
    input  logic            rd_order,
    output logic [3:0]      ssm_word,
    output logic            flag_change,
    output logic            flag_order,
    output logic            irq
);
    tag_t tag;
    logic data_bit;
    logic commit;
    logic order_evt;
    logic change_evt;
    logic have_msg;
    ssm_t new_word;
    ssm_t stored;

    always_comb begin
        tag      = {ma_byte[TAG_MSB_POS], ma_byte[TAG_LSB_POS]};
        data_bit = ma_byte[DATA_POS];
    end

    e3_ssm_seq_chk u_seq (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .stb(frame_stb),
        .tag(tag), .order_evt(order_evt)
    );

    e3_ssm_asm u_asm (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .stb(frame_stb),
        .tag(tag), .data_bit(data_bit), .commit(commit), .word(new_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored   <= '0;
            have_msg <= 1'b0;
        end else if (!rx_en) begin
            have_msg <= 1'b0;
        end else if (commit) begin
            stored   <= new_word;
            have_msg <= 1'b1;
        end
    end

    always_comb begin
        change_evt = commit && have_msg && (new_word != stored);
    end

    e3_ssm_sticky u_flag_change (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .set(change_evt),
        .rd(rd_change), .flag(flag_change)
    );

    e3_ssm_sticky u_flag_order (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .set(order_evt),
        .rd(rd_order), .flag(flag_order)
    );

    always_comb begin
        ssm_word = stored;
        irq      = flag_change | flag_order;
    end

    assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> ($stable(ssm_word) && $stable(flag_change) && $stable(flag_order)));
    assert_word_moves_on_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ssm_word) |-> $past(commit));
    assert_change_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_change) |-> $past(commit));
    assert_order_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_order) |-> $past(order_evt));
    assert_no_commit_on_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
        order_evt |-> !commit);
endmodule

// File: tb/e3_ssm_rx_bench.sv
module e3_ssm_rx_bench;
    typedef struct {
        logic [3:0] ssm;
        logic       chg;
        logic       ord;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic [7:0] ma_byte = '0;
    logic       rx_en = 1'b0;
    logic       rd_change = 1'b0;
    logic       rd_order = 1'b0;
    logic [3:0] ssm_word;
    logic       flag_change, flag_order, irq;

    int checks = 0;
    int errors = 0;
    exp_t q[$];
    bit done = 0;

    // model state
    logic [3:0] m_ssm = '0, m_part = '0;
    logic       m_chg = 0, m_ord = 0, m_have_msg = 0, m_have_prev = 0;
    logic [1:0] m_prev = '0;
    int         m_st = 0;

    always #10 clk = ~clk;

    e3_ssm_rx u_e3_ssm_rx (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .ma_byte(ma_byte),
        .rx_en(rx_en), .rd_change(rd_change), .rd_order(rd_order),
        .ssm_word(ssm_word), .flag_change(flag_change), .flag_order(flag_order), .irq(irq)
    );

    task automatic check1(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_exp(string req);
        exp_t e;
        e.ssm = m_ssm; e.chg = m_chg; e.ord = m_ord; e.req = req;
        q.push_back(e);
    endtask

    // one cycle of stimulus; model updated from the requirements
    task automatic cycle(logic stb, logic [1:0] tag, logic b, logic rc, logic ro, string req);
        logic set_c, set_o;
        @(negedge clk);
        frame_stb = stb; ma_byte = {5'b10100, tag[1], tag[0], b};
        rd_change = rc; rd_order = ro;
        set_c = 0; set_o = 0;
        if (!rx_en) begin
            m_have_prev = 0; m_st = 0; m_have_msg = 0;
        end else begin
            if (stb) begin
                if (m_have_prev && tag != m_prev + 2'd1) set_o = 1;
                m_prev = tag; m_have_prev = 1;
                if (m_st != 0 && int'(tag) == m_st) begin
                    m_part[3 - int'(tag)] = b;
                    if (tag == 2'b11) begin
                        if (m_have_msg && m_part != m_ssm) set_c = 1;
                        m_ssm = m_part; m_have_msg = 1; m_st = 0;
                    end else m_st++;
                end else if (tag == 2'b00) begin
                    m_part[3] = b; m_st = 1;
                end else m_st = 0;
            end
            if (set_c) m_chg = 1; else if (rc) m_chg = 0;
            if (set_o) m_ord = 1; else if (ro) m_ord = 0;
        end
        @(posedge clk); #1;
        frame_stb = 0; rd_change = 0; rd_order = 0;
        push_exp(req);
    endtask

    task automatic frame(logic [1:0] tag, logic b, string req);
        cycle(1'b1, tag, b, 1'b0, 1'b0, req);
    endtask

    task automatic message(logic [3:0] w, string req);
        for (int i = 0; i < 4; i++) frame(2'(i), w[3 - i], req);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check1(e.req, "ssm_word", int'(ssm_word), int'(e.ssm));
                check1(e.req, "flag_change", int'(flag_change), int'(e.chg));
                check1(e.req, "flag_order", int'(flag_order), int'(e.ord));
                check1("R9", "irq", int'(irq), int'(e.chg | e.ord));
            end
        end
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        push_exp("R10");                       // reset state
        @(negedge clk); rst_n = 1; rx_en = 1;
        cycle(0, 2'b00, 0, 0, 0, "R10");

        message(4'b1010, "R3");                // first message: no change flag
        message(4'b1010, "R4");                // identical: no flag
        message(4'b0110, "R4");                // differs: flag set, irq
        cycle(0, 2'b00, 0, 1, 0, "R8");        // read clears
        message(4'b1000, "R1");
        message(4'b0001, "R1");
        cycle(0, 2'b00, 0, 1, 0, "R8");

        // R5 / R6: break sequence mid-message
        frame(2'b00, 1, "R6");
        frame(2'b01, 1, "R6");
        frame(2'b11, 1, "R5");                 // out of order, no commit
        frame(2'b10, 0, "R6");                 // still out of order, hunting
        frame(2'b11, 0, "R6");                 // in order, but hunting: no commit
        cycle(0, 2'b00, 0, 0, 1, "R8");
        // R6: tag 00 mid-message restarts with that frame
        frame(2'b00, 1, "R6");
        frame(2'b01, 1, "R6");
        frame(2'b00, 0, "R6");                 // break, restart here
        frame(2'b01, 1, "R6");
        frame(2'b10, 0, "R6");
        frame(2'b11, 0, "R6");                 // commits 0100
        // R8: set and read in same cycle
        cycle(1, 2'b10, 1, 0, 1, "R8");        // after 11, tag 10 is out of order
        cycle(0, 2'b00, 0, 1, 1, "R8");

        // R7: disabled window
        frame(2'b00, 1, "R7");                 // partial before disable
        frame(2'b11, 1, "R7");                 // set order flag
        @(negedge clk); rx_en = 0;
        cycle(1, 2'b01, 1, 1, 1, "R7");
        message(4'b1111, "R7");
        cycle(0, 2'b00, 0, 1, 1, "R7");
        @(negedge clk); rx_en = 1;
        cycle(0, 2'b00, 0, 1, 1, "R8");
        frame(2'b10, 1, "R5");                 // first after enable: not flagged
        frame(2'b11, 1, "R5");
        message(4'b1101, "R3");                // first after enable: no change flag
        message(4'b0010, "R4");

        wait (q.size() == 0);
        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule